// File: doc/BRIEF.md
# Configurable Multi-Function IO Port

This block is one eight-pin bidirectional bank. Each pin has its own two-bit function code in a register that software writes. A pin can be a plain input, a plain output, or a pin of one of three serial engines: a SPI master, an I2C controller or a UART. The engines sit next to the bank. The bank only decides, per pin and at run time, who drives the pin's output value and output-enable, and which pin level each engine sees.

Every pin level passes through a two-flop synchroniser. That synchronised level feeds the input register and the engine inputs. A pin configured as a plain input can raise an interrupt on either edge when its enable bit is set. Flags are cleared by writing ones.

A single-cycle write port and a combinational read port reach six registers. Each register is 16 bits wide, and bit i of an eight-bit register belongs to pin i. The registers are: direction at offset 0, output data at 1, input data at 2 (read only), function select at 3, interrupt enable at 4 and interrupt flags at 5.

Top module: `ioPortBank`

## Requirements
- R1: After reset, every register reads 0, every pin has its output-enable low, and `irq` is low.
- R2: A pin with function code 00 and direction bit 1 drives its output-enable high and drives `pinOut` with its output-data bit.
- R3: A pin with function code 00 and direction bit 0 keeps its output-enable low. Its level appears in the input register (offset 2) two clock edges after it changes, and not after one.
- R4: The function code of pin i is the select register (offset 3) bits [2i+1:2i], with 00 plain IO, 01 SPI, 10 I2C and 11 UART. A non-zero code overrides the direction and output-data bits of that pin.
- R5: SPI pin map: pin 0 carries the clock out, pin 1 the data out and pin 3 the chip enable out, all always enabled. Pin 2 is data in and feeds `spiMiso` from its synchronised level. `spiMiso` is 0 when pin 2 is not in SPI mode.
- R6: I2C pin map: pin 4 is data and pin 5 is clock. Both are open-drain: the output-enable follows the engine's pull-low request and the driven value is always 0. `i2cSdaIn` and `i2cSclIn` carry the synchronised pin level, and read 1 when the pin is not in I2C mode.
- R7: UART pin map: pin 6 drives `uartTx` with output-enable high. Pin 7 feeds `uartRx` from its synchronised level, and `uartRx` is 1 when pin 7 is not in UART mode.
- R8: A pin set to an engine that has no output role on that pin keeps its output-enable low.
- R9: A pin in plain-input mode with its enable bit (offset 4) set raises its flag bit (offset 5) on a rising or falling synchronised edge. `irq` is high while any flag is set. No flag rises for a pin whose enable bit is clear, or for a pin that is an output or belongs to an engine.
- R10: Writing 1 to a flag bit clears it. Writing 0 leaves it unchanged.
- R11: Addresses 6 and 7 read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| regAddr | input | 3 | Register offset |
| regWrEn | input | 1 | Write strobe, one cycle |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Read data for `regAddr` |
| pinIn | input | 8 | Pin levels from the pads |
| pinOut | output | 8 | Pin drive values |
| pinOe | output | 8 | Pin output-enables |
| irq | output | 1 | Interrupt, OR of all flags |
| spiSck | input | 1 | SPI engine clock out |
| spiMosi | input | 1 | SPI engine data out |
| spiCs | input | 1 | SPI engine chip enable out |
| spiMiso | output | 1 | SPI engine data in |
| i2cSdaLow | input | 1 | I2C engine pulls data low |
| i2cSclLow | input | 1 | I2C engine pulls clock low |
| i2cSdaIn | output | 1 | I2C data level to engine |
| i2cSclIn | output | 1 | I2C clock level to engine |
| uartTx | input | 1 | UART engine transmit |
| uartRx | output | 1 | UART receive level to engine |

## Verification
The pin mux is tried with whole-bank selections of each engine. These show which pins an engine may drive and which it must release. Mixed selections, with SPI on the low nibble and plain IO on the rest, show that a function code overrides direction per pin and not per bank. Engine inputs are compared before and after their pin is taken away, which separates a real pin level from the idle value. The interrupt logic is driven with rising and falling edges on enabled and disabled pins, on an output pin and with partial-mask clears, so a flag raised by the wrong source, or cleared by a zero bit, shows up.

// File: rtl/ioport_pkg.sv
package ioport_pkg;
  localparam int NUM_PINS = 8;
  localparam int REG_W    = 2 * NUM_PINS;

  // fixed engine pin map
  localparam int PIN_SCK  = 0;
  localparam int PIN_MOSI = 1;
  localparam int PIN_MISO = 2;
  localparam int PIN_CS   = 3;
  localparam int PIN_SDA  = 4;
  localparam int PIN_SCL  = 5;
  localparam int PIN_TX   = 6;
  localparam int PIN_RX   = 7;

  typedef enum logic [1:0] {
    FN_GPIO = 2'b00,
    FN_SPI  = 2'b01,
    FN_I2C  = 2'b10,
    FN_UART = 2'b11
  } pinFn_e;

  typedef enum logic [2:0] {
    RS_DIR, RS_OUT, RS_IN, RS_SEL, RS_IE, RS_FLAG, RS_NONE
  } rdSel_e;

  typedef struct packed {
    logic             wrDir;
    logic             wrOut;
    logic             wrSel;
    logic             wrIe;
    logic             wrClr;
    rdSel_e           rdSel;
    logic [REG_W-1:0] data;
  } ctrlStrobe_t;
endpackage

// File: rtl/ioPortSync.sv
module ioPortSync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain[0] <= '0;
    else       chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain[s] <= '0;
      else       chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ioPortCtrl.sv
module ioPortCtrl
  import ioport_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [REG_W-1:0]  regWrData,
  output ctrlStrobe_t       strobe
);
  localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_OUT  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_IN   = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_SEL  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_IE   = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(5);

  always_comb begin
    strobe       = '0;
    strobe.data  = regWrData;
    strobe.rdSel = RS_NONE;
    case (regAddr)
      A_DIR:  begin strobe.wrDir = regWrEn; strobe.rdSel = RS_DIR;  end
      A_OUT:  begin strobe.wrOut = regWrEn; strobe.rdSel = RS_OUT;  end
      A_IN:   strobe.rdSel = RS_IN;
      A_SEL:  begin strobe.wrSel = regWrEn; strobe.rdSel = RS_SEL;  end
      A_IE:   begin strobe.wrIe  = regWrEn; strobe.rdSel = RS_IE;   end
      A_FLAG: begin strobe.wrClr = regWrEn; strobe.rdSel = RS_FLAG; end
      default: ;
    endcase
  end

  AST_UNMAPPED_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr > A_FLAG) |-> !(strobe.wrDir || strobe.wrOut || strobe.wrSel || strobe.wrIe || strobe.wrClr)); // R11
  AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $countones({strobe.wrDir, strobe.wrOut, strobe.wrSel, strobe.wrIe, strobe.wrClr}) <= 1); // R11
endmodule

// File: rtl/ioPortDatapath.sv
module ioPortDatapath
  import ioport_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         strobe,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOe,
  output logic [REG_W-1:0]    rdData,
  output logic                irq,
  input  logic                spiSck,
  input  logic                spiMosi,
  input  logic                spiCs,
  output logic                spiMiso,
  input  logic                i2cSdaLow,
  input  logic                i2cSclLow,
  output logic                i2cSdaIn,
  output logic                i2cSclIn,
  input  logic                uartTx,
  output logic                uartRx
);
  localparam int PAD_W = REG_W - NUM_PINS;

  logic [NUM_PINS-1:0] dirR, outR, ieR, flagR, pinPrev, pinSync;
  logic [NUM_PINS-1:0] isGpioIn, edgeHit, clrMask;
  logic [REG_W-1:0]    selR;
  pinFn_e              fn [NUM_PINS];

  ioPortSync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .d(pinIn), .q(pinSync)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirR <= '0; outR <= '0; ieR <= '0; selR <= '0;
    end else begin
      if (strobe.wrDir) dirR <= strobe.data[NUM_PINS-1:0];
      if (strobe.wrOut) outR <= strobe.data[NUM_PINS-1:0];
      if (strobe.wrIe)  ieR  <= strobe.data[NUM_PINS-1:0];
      if (strobe.wrSel) selR <= strobe.data;
    end
  end

  assign clrMask = strobe.wrClr ? strobe.data[NUM_PINS-1:0] : '0;
  assign edgeHit = (pinSync ^ pinPrev) & isGpioIn & ieR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinPrev <= '0;
      flagR   <= '0;
    end else begin
      pinPrev <= pinSync;
      flagR   <= (flagR & ~clrMask) | edgeHit;
    end
  end

  assign irq = |flagR;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic oeB, outB;
    assign fn[i]       = pinFn_e'(selR[2*i +: 2]);
    assign isGpioIn[i] = (fn[i] == FN_GPIO) && !dirR[i];

    always_comb begin
      oeB  = 1'b0;
      outB = 1'b0;
      case (fn[i])
        FN_GPIO: begin oeB = dirR[i]; outB = outR[i]; end
        FN_SPI: begin
          if (i == PIN_SCK)       begin oeB = 1'b1; outB = spiSck;  end
          else if (i == PIN_MOSI) begin oeB = 1'b1; outB = spiMosi; end
          else if (i == PIN_CS)   begin oeB = 1'b1; outB = spiCs;   end
        end
        FN_I2C: begin
          if (i == PIN_SDA)      oeB = i2cSdaLow;
          else if (i == PIN_SCL) oeB = i2cSclLow;
        end
        FN_UART: begin
          if (i == PIN_TX) begin oeB = 1'b1; outB = uartTx; end
        end
        default: ;
      endcase
    end
    assign pinOe[i]  = oeB;
    assign pinOut[i] = outB;

    AST_I2C_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rstN)
      (fn[i] == FN_I2C && pinOe[i]) |-> !pinOut[i]); // R6
    AST_GPIO_IN_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
      (fn[i] == FN_GPIO && !dirR[i]) |-> !pinOe[i]); // R3
    AST_NO_ROLE_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
      ((fn[i] == FN_SPI && (i == PIN_MISO || i > PIN_CS)) ||
       (fn[i] == FN_I2C && i != PIN_SDA && i != PIN_SCL) ||
       (fn[i] == FN_UART && i != PIN_TX)) |-> !pinOe[i]); // R8
    AST_FLAG_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
      $rose(flagR[i]) |-> $past(isGpioIn[i] && ieR[i])); // R9
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
      (clrMask[i] && !edgeHit[i]) |=> !flagR[i]); // R10
  end

  assign spiMiso  = (fn[PIN_MISO] == FN_SPI)  ? pinSync[PIN_MISO] : 1'b0;
  assign i2cSdaIn = (fn[PIN_SDA]  == FN_I2C)  ? pinSync[PIN_SDA]  : 1'b1;
  assign i2cSclIn = (fn[PIN_SCL]  == FN_I2C)  ? pinSync[PIN_SCL]  : 1'b1;
  assign uartRx   = (fn[PIN_RX]   == FN_UART) ? pinSync[PIN_RX]   : 1'b1;

  always_comb begin
    case (strobe.rdSel)
      RS_DIR:  rdData = {{PAD_W{1'b0}}, dirR};
      RS_OUT:  rdData = {{PAD_W{1'b0}}, outR};
      RS_IN:   rdData = {{PAD_W{1'b0}}, pinSync};
      RS_SEL:  rdData = selR;
      RS_IE:   rdData = {{PAD_W{1'b0}}, ieR};
      RS_FLAG: rdData = {{PAD_W{1'b0}}, flagR};
      default: rdData = '0;
    endcase
  end
endmodule

// File: rtl/ioPortBank.sv
module ioPortBank
  import ioport_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic                regWrEn,
  input  logic [REG_W-1:0]    regWrData,
  output logic [REG_W-1:0]    regRdData,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOe,
  output logic                irq,
  input  logic                spiSck,
  input  logic                spiMosi,
  input  logic                spiCs,
  output logic                spiMiso,
  input  logic                i2cSdaLow,
  input  logic                i2cSclLow,
  output logic                i2cSdaIn,
  output logic                i2cSclIn,
  input  logic                uartTx,
  output logic                uartRx
);
  ctrlStrobe_t strobe;

  ioPortCtrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .strobe(strobe)
  );

  ioPortDatapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe), .rdData(regRdData), .irq(irq),
    .spiSck(spiSck), .spiMosi(spiMosi), .spiCs(spiCs), .spiMiso(spiMiso),
    .i2cSdaLow(i2cSdaLow), .i2cSclLow(i2cSclLow),
    .i2cSdaIn(i2cSdaIn), .i2cSclIn(i2cSclIn),
    .uartTx(uartTx), .uartRx(uartRx)
  );
endmodule

// File: tb/tb_ioPortBank.sv
module tb_ioPortBank;
  logic        clk = 0;
  logic        rstN = 0;
  logic [2:0]  regAddr = '0;
  logic        regWrEn = 0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic [7:0]  pinIn = '0;
  logic [7:0]  pinOut, pinOe;
  logic        irq, spiMiso, i2cSdaIn, i2cSclIn, uartRx;
  logic        spiSck = 0, spiMosi = 0, spiCs = 0;
  logic        i2cSdaLow = 0, i2cSclLow = 0, uartTx = 1;

  int nRun = 0;
  int nFail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  ioPortBank dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe), .irq(irq),
    .spiSck(spiSck), .spiMosi(spiMosi), .spiCs(spiCs), .spiMiso(spiMiso),
    .i2cSdaLow(i2cSdaLow), .i2cSclLow(i2cSclLow),
    .i2cSdaIn(i2cSdaIn), .i2cSclIn(i2cSclIn),
    .uartTx(uartTx), .uartRx(uartRx)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1;
    @(negedge clk);
    regWrEn = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
    #1;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      chk("R1 reg after reset", v, 16'h0);
    end
    chk("R1 oe after reset", {8'h0, pinOe}, 16'h0);
    chk("R1 irq after reset", {15'h0, irq}, 16'h0);
  endtask

  task automatic t_gpioOut();
    wr(0, 16'h000F);
    wr(1, 16'h0005);
    #1;
    chk("R2 oe", {8'h0, pinOe}, 16'h000F);
    chk("R2 out", {8'h0, pinOut & 8'h0F}, 16'h0005);
    wr(1, 16'h000A);
    #1;
    chk("R2 out second pattern", {8'h0, pinOut & 8'h0F}, 16'h000A);
    wr(0, 16'h0000);
    wr(1, 16'h0000);
  endtask

  task automatic t_gpioIn();
    logic [15:0] v;
    @(negedge clk);
    pinIn = 8'hA5;
    rd(2, v);  // one posedge since change
    chk("R3 input not yet after one edge", v, 16'h0000);
    rd(2, v);  // two posedges
    chk("R3 input after two edges", v, 16'h00A5);
    chk("R3 input pins released", {8'h0, pinOe}, 16'h0);
    pinIn = 8'h00;
    settle();
  endtask

  task automatic t_spi();
    wr(0, 16'h0000);
    spiSck = 1; spiMosi = 0; spiCs = 1;
    wr(3, 16'h0055);  // pins 0..3 SPI
    #1;
    chk("R4 R5 spi oe overrides dir", {8'h0, pinOe}, 16'h000B);
    chk("R5 spi outputs", {8'h0, pinOut & 8'h0F}, 16'h0009);
    spiMosi = 1; spiSck = 0;
    #1;
    chk("R5 spi outputs follow", {8'h0, pinOut & 8'h0F}, 16'h000A);
    pinIn[2] = 1;
    settle();
    chk("R5 miso from pin2", {15'h0, spiMiso}, 16'h1);
    wr(3, 16'h0045);  // pin2 back to plain IO
    #1;
    chk("R5 miso idle when pin2 not spi", {15'h0, spiMiso}, 16'h0);
    pinIn = 0;
    wr(3, 16'h0000);
    settle();
  endtask

  task automatic t_i2c();
    i2cSdaLow = 1; i2cSclLow = 0;
    wr(3, 16'h0A00);  // pins 4,5 I2C
    #1;
    chk("R6 sda pulled low oe", {15'h0, pinOe[4]}, 16'h1);
    chk("R6 sda value low", {15'h0, pinOut[4]}, 16'h0);
    chk("R6 scl released", {15'h0, pinOe[5]}, 16'h0);
    pinIn[4] = 0; pinIn[5] = 1;
    settle();
    chk("R6 sda in level", {15'h0, i2cSdaIn}, 16'h0);
    chk("R6 scl in level", {15'h0, i2cSclIn}, 16'h1);
    wr(3, 16'h0000);
    #1;
    chk("R6 sda idle high when unselected", {15'h0, i2cSdaIn}, 16'h1);
    pinIn = 0; i2cSdaLow = 0;
    settle();
  endtask

  task automatic t_uart();
    uartTx = 0;
    wr(3, 16'hF000);  // pins 6,7 UART
    #1;
    chk("R7 tx oe", {14'h0, pinOe[7:6]}, 16'h1);
    chk("R7 tx low", {15'h0, pinOut[6]}, 16'h0);
    uartTx = 1;
    #1;
    chk("R7 tx high", {15'h0, pinOut[6]}, 16'h1);
    pinIn[7] = 0;
    settle();
    chk("R7 rx level", {15'h0, uartRx}, 16'h0);
    wr(3, 16'h0000);
    #1;
    chk("R7 rx idle when unselected", {15'h0, uartRx}, 16'h1);
  endtask

  task automatic t_noRole();
    wr(0, 16'h00FF);
    wr(1, 16'h00FF);
    wr(3, 16'hFFFF);
    #1;
    chk("R8 all uart", {8'h0, pinOe}, 16'h0040);
    wr(3, 16'h5555);
    #1;
    chk("R8 all spi", {8'h0, pinOe}, 16'h000B);
    i2cSdaLow = 1; i2cSclLow = 1;
    wr(3, 16'hAAAA);
    #1;
    chk("R8 all i2c oe", {8'h0, pinOe}, 16'h0030);
    chk("R8 R6 all i2c drive zero", {8'h0, pinOut}, 16'h0000);
    i2cSdaLow = 0; i2cSclLow = 0;
    wr(3, 16'h0000);
    wr(0, 16'h0000);
    wr(1, 16'h0000);
  endtask

  task automatic t_irq();
    logic [15:0] v;
    wr(0, 16'h0002);  // pin1 output
    wr(4, 16'h0003);  // enables on pins 0,1
    @(negedge clk);
    pinIn[0] = 1;
    settle();
    rd(5, v);
    chk("R9 rising edge flag", v, 16'h0001);
    chk("R9 irq high", {15'h0, irq}, 16'h1);
    pinIn[2] = 1; pinIn[1] = 1;
    settle();
    rd(5, v);
    chk("R9 no flag disabled or output pin", v, 16'h0001);
    wr(5, 16'h0000);
    rd(5, v);
    chk("R10 zero write keeps flag", v, 16'h0001);
    wr(5, 16'h0001);
    rd(5, v);
    chk("R10 one write clears", v, 16'h0000);
    chk("R10 irq low after clear", {15'h0, irq}, 16'h0);
    pinIn[0] = 0;
    settle();
    rd(5, v);
    chk("R9 falling edge flag", v, 16'h0001);
    wr(5, 16'h00FF);
    wr(3, 16'h0001);  // pin0 SPI
    pinIn[0] = 1;
    settle();
    rd(5, v);
    chk("R9 no flag on engine pin", v, 16'h0000);
    wr(3, 16'h0000);
    wr(4, 16'h0000);
    pinIn = 0;
    settle();
    wr(5, 16'h00FF);
  endtask

  task automatic t_unmapped();
    logic [15:0] v;
    wr(0, 16'h0012);
    wr(6, 16'hFFFF);
    wr(7, 16'hFFFF);
    rd(6, v);
    chk("R11 addr6 reads zero", v, 16'h0);
    rd(7, v);
    chk("R11 addr7 reads zero", v, 16'h0);
    rd(0, v);
    chk("R11 dir unchanged", v, 16'h0012);
    rd(3, v);
    chk("R11 sel unchanged", v, 16'h0000);
    rd(4, v);
    chk("R11 ie unchanged", v, 16'h0000);
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    t_reset();
    t_gpioOut();
    t_gpioIn();
    t_spi();
    t_i2c();
    t_uart();
    t_noRole();
    t_irq();
    t_unmapped();
    finished = 1;
    finishRun();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog actual=running expected=done");
      finishRun();
    end
  end
endmodule